// File: doc/BRIEF.md
# Slot-Based Serial Audio Receive Deserializer

This block takes one serial audio data line and turns each time slot into a 24-bit word. A bit-valid strobe marks the system-clock cycles on which the line holds a new bit. A slot-start strobe that arrives together with a bit-valid strobe marks the first bit of a slot. The block shifts in as many bits as the selected word length. On the last of them it copies the word into a receive data register that the host can only read. The word is always left-aligned, so its most significant bit sits at bit 23 and every bit below its least significant bit is zero.

Bits can arrive most significant first or least significant first. Either way the stored word has the same layout. A full flag shows that an unread word is waiting. A sticky overrun bit records that a word was replaced before the host read it. An interrupt request follows the full flag when the interrupt enable is set. A host read strobe clears both status bits.

Top module: `serial_rx_slot`

## Requirements
- R1: `len_sel` sets the word length: code 0 is 8 bits, 1 is 12, 2 is 16, 3 is 20 and 4 is 24. Codes 5, 6 and 7 behave as 24 bits.
- R2: With `lsb_first`=0 the first bit of a slot is the word's MSB and lands at `rx_word` bit 23.
- R3: With `lsb_first`=1 the first bit of a slot is the word's LSB. The stored word is still left-aligned, with the LSB at bit 24-L and the last received bit at bit 23.
- R4: For a word of L bits, `rx_word` bits 23-L down to 0 read as zero.
- R5: A slot starts on a cycle where `bit_en` and `slot_start` are both 1. Such a cycle in the middle of a word discards the partial word and starts again. Bits after the last bit of a word are ignored until the next slot start. Cycles with `bit_en`=0 shift nothing.
- R6: On the clock edge that takes the L-th bit, `rx_word` loads the word and `rx_full` goes to 1. `rx_word` changes at no other time.
- R7: A `host_rd` pulse clears `rx_full` and `rx_ovr`. If a transfer happens in the same cycle as the read, `rx_full` stays 1 and `rx_ovr` is not set.
- R8: A transfer while `rx_full` is 1 and `host_rd` is 0 sets `rx_ovr`, which stays set until a read. The new word replaces the old one.
- R9: `rx_irq` is 1 exactly when `rx_full` is 1 and `irq_en` is 1.
- R10: After reset, `rx_word` is zero and `rx_full`, `rx_ovr` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | A new serial bit is valid this cycle |
| slot_start | input | 1 | With `bit_en`, marks the first bit of a slot |
| sdin | input | 1 | Serial data line |
| len_sel | input | 3 | Word length code |
| lsb_first | input | 1 | 1: LSB received first; 0: MSB received first |
| irq_en | input | 1 | Receive interrupt enable |
| host_rd | input | 1 | Host read strobe, one cycle |
| rx_word | output | 24 | Left-aligned receive data register |
| rx_full | output | 1 | Unread word present |
| rx_ovr | output | 1 | Word replaced before it was read |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench sends every word length in both bit orders. It uses patterns whose end bits are 1, so a wrong alignment shift or missing zero fill changes the value it reads back. It also sends slots with extra bits after the word, with a slot start in the middle of a word, and with a length code outside the named range. A design that counted one bit too many or too few, or that did not restart on a slot start, would store a shifted or mixed word. The bench also places a host read in the same cycle as a transfer and lets a second word arrive without a read. These catch a full flag lost to the read, and an overrun bit that is set falsely or missed.

// File: rtl/serial_rx_slot.sv
module serial_rx_slot (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        slot_start,
  input  logic        sdin,
  input  logic [2:0]  len_sel,
  input  logic        lsb_first,
  input  logic        irq_en,
  input  logic        host_rd,
  output logic [23:0] rx_word,
  output logic        rx_full,
  output logic        rx_ovr,
  output logic        rx_irq
);
  logic [23:0] shreg, shnext, aligned;
  logic [4:0]  cnt, cnt_next, len;
  logic        active, taking, xfer;

  always_comb begin
    case (len_sel)
      3'd0:    len = 5'd8;
      3'd1:    len = 5'd12;
      3'd2:    len = 5'd16;
      3'd3:    len = 5'd20;
      default: len = 5'd24;
    endcase
  end

  assign taking   = bit_en && (slot_start || active);
  assign cnt_next = slot_start ? 5'd1 : cnt + 5'd1;
  assign xfer     = taking && (cnt_next == len);

  assign shnext = slot_start
                ? (lsb_first ? {sdin, 23'd0} : {23'd0, sdin})
                : (lsb_first ? {sdin, shreg[23:1]} : {shreg[22:0], sdin});

  assign aligned = lsb_first ? shnext : (shnext << (5'd24 - len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (taking) begin
      shreg  <= shnext;
      cnt    <= cnt_next;
      active <= cnt_next < len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (xfer) rx_word <= aligned;
      if (xfer) rx_full <= 1'b1;
      else if (host_rd) rx_full <= 1'b0;
      if (xfer && rx_full && !host_rd) rx_ovr <= 1'b1;
      else if (host_rd) rx_ovr <= 1'b0;
    end
  end

  assign rx_irq = rx_full & irq_en;
endmodule

// File: rtl/serial_rx_slot_chk.sv
module serial_rx_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_en,
  input logic        host_rd,
  input logic [2:0]  len_sel,
  input logic [23:0] rx_word,
  input logic        rx_full,
  input logic        rx_ovr,
  input logic        rx_irq
);
  a_r6_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(rx_word));
  a_r6_word_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_full);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !bit_en |=> !rx_full && !rx_ovr);
  a_r8_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_full));
  a_r4_zero_fill8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) && $past(len_sel) == 3'd0 |-> rx_word[15:0] == 16'd0);
  a_r9_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
endmodule

bind serial_rx_slot serial_rx_slot_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .host_rd(host_rd),
  .len_sel(len_sel), .rx_word(rx_word), .rx_full(rx_full),
  .rx_ovr(rx_ovr), .rx_irq(rx_irq));

// File: tb/test_serial_rx_slot.sv
module test_serial_rx_slot;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, slot_start = 0, sdin = 0, lsb_first = 0, irq_en = 0, host_rd = 0;
  logic [2:0] len_sel = 0;
  logic [23:0] rx_word;
  logic rx_full, rx_ovr, rx_irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  serial_rx_slot i_serial_rx_slot (.*);

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    case (c)
      0: return 8; 1: return 12; 2: return 16; 3: return 20; default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] w, input int l);
    logic [31:0] m;
    m = {8'd0, w} & ((32'h1 << l) - 1);
    return 24'(m << (24 - l));
  endfunction

  task automatic send_bit(input logic b, input logic first, input logic rd);
    @(negedge clk);
    bit_en = 1; sdin = b; slot_start = first; host_rd = rd;
    @(negedge clk);
    bit_en = 0; slot_start = 0; host_rd = 0;
  endtask

  task automatic send_word(input logic [2:0] code, input logic lsb, input logic [23:0] w,
                           input logic rd_last, input logic check_early);
    int l = len_of(code);
    logic early_full = rx_full;
    len_sel = code; lsb_first = lsb;
    for (int k = 0; k < l; k++) begin
      int idx = lsb ? k : l - 1 - k;
      send_bit(w[idx], k == 0, rd_last && k == l - 1);
      if (check_early && k == l - 2) chk("R6 full before last bit", {23'd0, rx_full}, {23'd0, early_full});
    end
  endtask

  task automatic do_read();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
    chk("R7 read clears full", {23'd0, rx_full}, 24'd0);
    chk("R7 read clears ovr", {23'd0, rx_ovr}, 24'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset word", rx_word, 24'd0);
    chk("R10 reset flags", {21'd0, rx_full, rx_ovr, rx_irq}, 24'd0);
  endtask

  task automatic t_msb_24();
    irq_en = 1;
    send_word(3'd4, 0, 24'hA5C3E1, 0, 1);
    chk("R2 msb first 24", rx_word, 24'hA5C3E1);
    chk("R6 full after last", {23'd0, rx_full}, 24'd1);
    chk("R9 irq with enable", {23'd0, rx_irq}, 24'd1);
    do_read();
    chk("R9 irq off after read", {23'd0, rx_irq}, 24'd0);
  endtask

  task automatic t_lengths();
    for (int c = 0; c < 4; c++) begin
      logic [23:0] w = 24'h9F0FF1 ^ 24'(c * 24'h111111);
      w[0] = 1;
      send_word(3'(c), 0, w, 0, 1);
      chk("R1 R4 msb length", rx_word, expect_word(w, len_of(3'(c))));
      do_read();
    end
  endtask

  task automatic t_lsb();
    send_word(3'd1, 1, 24'h000C35, 0, 0);
    chk("R3 lsb first 12", rx_word, expect_word(24'h000C35, 12));
    do_read();
    send_word(3'd4, 1, 24'h81F3D7, 0, 0);
    chk("R3 lsb first 24", rx_word, 24'h81F3D7);
    do_read();
    send_word(3'd0, 1, 24'h0000C1, 0, 0);
    chk("R3 R4 lsb first 8", rx_word, 24'hC10000);
    do_read();
  endtask

  task automatic t_code_high();
    send_word(3'd6, 0, 24'hC0FFE3, 0, 0);
    chk("R1 code 6 as 24", rx_word, 24'hC0FFE3);
    do_read();
  endtask

  task automatic t_overrun();
    send_word(3'd2, 0, 24'h00BEEF, 0, 0);
    chk("R8 no ovr first", {23'd0, rx_ovr}, 24'd0);
    send_word(3'd2, 0, 24'h001235, 0, 0);
    chk("R8 ovr set", {23'd0, rx_ovr}, 24'd1);
    chk("R8 new word kept", rx_word, 24'h123500);
    repeat (3) @(negedge clk);
    chk("R8 ovr sticky", {23'd0, rx_ovr}, 24'd1);
    do_read();
  endtask

  task automatic t_framing();
    send_word(3'd2, 0, 24'h00F00D, 0, 0);
    for (int k = 0; k < 6; k++) send_bit(1'b1, 0, 0);
    chk("R5 trailing bits ignored", rx_word, 24'hF00D00);
    chk("R5 no ovr from trailing", {23'd0, rx_ovr}, 24'd0);
    do_read();
    len_sel = 3'd0; lsb_first = 0;
    for (int k = 0; k < 5; k++) send_bit(1'b1, k == 0, 0);
    chk("R5 partial not stored", {23'd0, rx_full}, 24'd0);
    send_word(3'd0, 0, 24'h000081, 0, 0);
    chk("R5 restart on slot start", rx_word, 24'h810000);
    do_read();
  endtask

  task automatic t_read_same_cycle();
    send_word(3'd0, 0, 24'h00003C, 0, 0);
    send_word(3'd0, 0, 24'h0000E7, 1, 0);
    chk("R7 full kept on same-cycle read", {23'd0, rx_full}, 24'd1);
    chk("R7 no ovr on same-cycle read", {23'd0, rx_ovr}, 24'd0);
    chk("R7 word same-cycle", rx_word, 24'hE70000);
    do_read();
  endtask

  task automatic t_irq_off();
    irq_en = 0;
    send_word(3'd3, 0, 24'h0ABCDF, 0, 0);
    chk("R9 irq masked", {22'd0, rx_full, rx_irq}, 24'd2);
    do_read();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_msb_24();
    t_lengths();
    t_lsb();
    t_code_high();
    t_overrun();
    t_framing();
    t_read_same_cycle();
    t_irq_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule